// File: doc/BRIEF.md
# Unified Translation Lookaside Buffer Lookup with Access Checks

The block translates one 32-bit virtual data address at a time through a fully associative table of address-translation entries. Each entry describes one page: its virtual page number, the physical page number it maps to, an address-space identifier, a page size of 1 KB, 4 KB, 64 KB or 1 MB, and flags for valid, shared, dirty and cacheable, plus a two-bit permission field. A lookup compares the virtual address against every entry at once. It then reports one of three results. The first is a successful translation with the physical address. The second is a fault code, for a miss, a multiple match or a permission problem. The third is the code that tells the operating system a clean page is being written for the first time.

Requests arrive on a valid/ready channel and results leave on another. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its result appears with `rsp_valid` high after that same edge and stays unchanged until an edge where `rsp_ready` is high. `req_ready` is high whenever no result is waiting or the waiting result is being taken in the same cycle, so a lookup can be accepted on every cycle while the consumer keeps `rsp_ready` high.

The table is loaded through a plain write port that replaces the entry at a given index. A 6-bit replacement counter, exposed as `urc`, advances once for every accepted lookup. It is bounded by a software-set limit `urb`, so that software can use it as the index for its next entry load.

Top module: `utlb_xlate`

## Requirements
- R1: An entry whose valid flag is 0 never matches. After reset every entry is invalid, so every lookup misses.
- R2: The entry's identifier is compared with `cur_asid` only when the entry's shared flag is 0 and identifier checking is on. Checking is on when `sv_mode` is 0 or when `req_priv` is 0 (user access). Otherwise the identifier is ignored.
- R3: The page size field selects how many virtual address bits are left out of the compare. Code 0 ignores bits 9:0, code 1 ignores bits 11:0, code 2 ignores bits 15:0 and code 3 ignores bits 19:0.
- R4: When two or more entries match, `rsp_code` is 0x140 and `rsp_hit` is 0.
- R5: When no entry matches, `rsp_code` is 0x040 for a read (`req_write`=0) and 0x060 for a write.
- R6: For a single match, the checks apply in this order, and the first one that applies sets the code. A user access to an entry with permission bit 1 clear gives 0x0A0 on a read and 0x0C0 on a write. A write to an entry with permission bit 0 clear gives 0x0C0. A write to an entry whose dirty flag is 0 gives 0x080. Otherwise the result is success with code 0x000.
- R7: On success `rsp_hit` is 1. `rsp_pa` is the physical page number shifted left by 10, with the bits below the page size cleared, ORed with those low bits of the virtual address. `rsp_cacheable` is the entry's cacheable flag. On any fault `rsp_hit`, `rsp_pa` and `rsp_cacheable` are 0.
- R8: `urc` resets to 0 and changes only on an accepted lookup. It becomes the old value plus one, or 0 when that sum is above a nonzero `urb` or above 63.
- R9: The result of a lookup accepted on a clock edge is visible after that edge. It is held stable while `rsp_ready` is 0, and `req_ready` is 0 during that time.
- R10: A write with `wr_en`=1 replaces the entry at `wr_idx` unconditionally on the clock edge. A lookup accepted on the same edge still sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_priv | input | 1 | 1 = privileged access, 0 = user access |
| cur_asid | input | 8 | Current address-space identifier |
| sv_mode | input | 1 | 1 turns off identifier checks for privileged accesses |
| urb | input | 6 | Replacement counter limit, 0 = no limit |
| wr_en | input | 1 | Write one table entry |
| wr_idx | input | 6 | Index of the entry to write |
| wr_vpn | input | 22 | Virtual page number (address bits 31:10) |
| wr_ppn | input | 22 | Physical page number (address bits 31:10) |
| wr_asid | input | 8 | Entry identifier |
| wr_size | input | 2 | Page size code (0 = 1 KB, 1 = 4 KB, 2 = 64 KB, 3 = 1 MB) |
| wr_valid | input | 1 | Entry valid flag |
| wr_shared | input | 1 | Entry shared flag |
| wr_dirty | input | 1 | Entry dirty flag |
| wr_cacheable | input | 1 | Entry cacheable flag |
| wr_prot | input | 2 | Permissions: bit 1 = user allowed, bit 0 = writes allowed |
| rsp_valid | output | 1 | Lookup result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_code | output | 12 | Fault code, 0 on success |
| rsp_pa | output | 32 | Physical address |
| rsp_cacheable | output | 1 | Cacheable flag of the matched entry |
| urc | output | 6 | Replacement counter |

## Verification
Directed lookups probe each compare rule on its own. Addresses that differ from an entry only in bits inside or just above its page size separate the four size codes. Identifier mismatches under each setting of `sv_mode`, `req_priv` and the shared flag separate filtered cases from unfiltered ones. Entries with permission and dirty settings that trip two checks at once show the order in which the checks are applied. Other directed cases cover duplicate entries, a write and a lookup on the same edge, and a stalled consumer. Constrained random traffic then runs over entries whose page numbers lie close together, with mixed sizes and identifiers, so that hits, misses and multiple matches all occur. The replacement counter is followed with and without a limit.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

  localparam int VA_W   = 32;
  localparam int PG_LSB = 10;
  localparam int VPN_W  = VA_W - PG_LSB;
  localparam int PPN_W  = 22;
  localparam int ASID_W = 8;
  localparam int CODE_W = 12;

  localparam logic [CODE_W-1:0] EC_NONE    = 12'h000;
  localparam logic [CODE_W-1:0] EC_MISS_RD = 12'h040;
  localparam logic [CODE_W-1:0] EC_MISS_WR = 12'h060;
  localparam logic [CODE_W-1:0] EC_INIT_WR = 12'h080;
  localparam logic [CODE_W-1:0] EC_PROT_RD = 12'h0A0;
  localparam logic [CODE_W-1:0] EC_PROT_WR = 12'h0C0;
  localparam logic [CODE_W-1:0] EC_MULTI   = 12'h140;

  // Fields needed once a match is known.
  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [1:0]       size;
    logic             dirty;
    logic             cacheable;
    logic [1:0]       prot;
  } tlb_pay_t;

  // One full table entry.
  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              valid;
    logic              shared;
    tlb_pay_t          pay;
  } tlb_ent_t;

  // Page-number bits that take part in the compare for a size code.
  function automatic logic [VPN_W-1:0] vpn_cmp_mask(input logic [1:0] sz);
    logic [VPN_W-1:0] m;
    m = '1;
    case (sz)
      2'd0:    m = '1;
      2'd1:    m[1:0] = '0;
      2'd2:    m[5:0] = '0;
      default: m[9:0] = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/utlb_store.sv
module utlb_store
  import utlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  tlb_ent_t                 wr_ent,
  output tlb_ent_t [N_ENTRIES-1:0] ents
);

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ents[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        ents[g] <= wr_ent;
      end
    end
  end

endmodule

// File: rtl/utlb_match.sv
module utlb_match
  import utlb_pkg::*;
#(
  parameter int N_ENTRIES = 64
) (
  input  tlb_ent_t [N_ENTRIES-1:0] ents,
  input  logic [VPN_W-1:0]         va_vpn,
  input  logic [ASID_W-1:0]        cur_asid,
  input  logic                     use_asid,
  output logic [N_ENTRIES-1:0]     hit_vec,
  output tlb_pay_t                 sel_pay
);

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    logic page_eq;
    logic asid_ok;
    always_comb begin
      page_eq    = ((ents[g].vpn ^ va_vpn) & vpn_cmp_mask(ents[g].pay.size)) == '0;
      asid_ok    = ents[g].shared || !use_asid || (ents[g].asid == cur_asid);
      hit_vec[g] = ents[g].valid && asid_ok && page_eq;
    end
  end

  // AND-OR select; only meaningful when exactly one bit of hit_vec is set.
  always_comb begin
    sel_pay = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (hit_vec[i]) sel_pay = tlb_pay_t'(sel_pay | ents[i].pay);
    end
  end

endmodule

// File: rtl/utlb_resolve.sv
module utlb_resolve
  import utlb_pkg::*;
#(
  parameter int N_ENTRIES = 64
) (
  input  logic [N_ENTRIES-1:0] hit_vec,
  input  tlb_pay_t             sel_pay,
  input  logic [VA_W-1:0]      va,
  input  logic                 is_write,
  input  logic                 is_user,
  output logic                 ok,
  output logic [CODE_W-1:0]    code,
  output logic [VA_W-1:0]      pa,
  output logic                 cacheable
);

  logic            any_hit;
  logic            multi_hit;
  logic [VA_W-1:0] off_mask;

  always_comb begin
    any_hit   = |hit_vec;
    multi_hit = |(hit_vec & (hit_vec - N_ENTRIES'(1)));
    off_mask  = ~{vpn_cmp_mask(sel_pay.size), {PG_LSB{1'b0}}};

    if (multi_hit) begin
      code = EC_MULTI;
    end else if (!any_hit) begin
      code = is_write ? EC_MISS_WR : EC_MISS_RD;
    end else if (is_user && !sel_pay.prot[1]) begin
      code = is_write ? EC_PROT_WR : EC_PROT_RD;
    end else if (is_write && !sel_pay.prot[0]) begin
      code = EC_PROT_WR;
    end else if (is_write && !sel_pay.dirty) begin
      code = EC_INIT_WR;
    end else begin
      code = EC_NONE;
    end

    ok        = (code == EC_NONE);
    pa        = ok ? (({sel_pay.ppn, {PG_LSB{1'b0}}} & ~off_mask) | (va & off_mask)) : '0;
    cacheable = ok && sel_pay.cacheable;
  end

endmodule

// File: rtl/utlb_urc.sv
module utlb_urc #(
  parameter int N_ENTRIES = 64,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [IDX_W-1:0] limit,
  output logic [IDX_W-1:0] count
);

  logic [IDX_W:0] nxt;
  logic           wrap;

  always_comb begin
    nxt  = {1'b0, count} + (IDX_W+1)'(1);
    wrap = ((limit != '0) && (nxt > {1'b0, limit})) ||
           (nxt > (IDX_W+1)'(N_ENTRIES - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (step) begin
      count <= wrap ? '0 : nxt[IDX_W-1:0];
    end
  end

endmodule

// File: rtl/utlb_xlate.sv
module utlb_xlate
  import utlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_va,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic [7:0]        cur_asid,
  input  logic              sv_mode,
  input  logic [IDX_W-1:0]  urb,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [21:0]       wr_vpn,
  input  logic [21:0]       wr_ppn,
  input  logic [7:0]        wr_asid,
  input  logic [1:0]        wr_size,
  input  logic              wr_valid,
  input  logic              wr_shared,
  input  logic              wr_dirty,
  input  logic              wr_cacheable,
  input  logic [1:0]        wr_prot,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [11:0]       rsp_code,
  output logic [31:0]       rsp_pa,
  output logic              rsp_cacheable,
  output logic [IDX_W-1:0]  urc
);

  tlb_ent_t [N_ENTRIES-1:0] ents;
  tlb_ent_t                 wr_ent;
  logic [N_ENTRIES-1:0]     hit_vec;
  tlb_pay_t                 sel_pay;
  logic                     fire;
  logic                     use_asid;
  logic                     res_ok;
  logic [CODE_W-1:0]        res_code;
  logic [VA_W-1:0]          res_pa;
  logic                     res_cache;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign use_asid  = !sv_mode || !req_priv;

  always_comb begin
    wr_ent               = '0;
    wr_ent.vpn           = wr_vpn;
    wr_ent.asid          = wr_asid;
    wr_ent.valid         = wr_valid;
    wr_ent.shared        = wr_shared;
    wr_ent.pay.ppn       = wr_ppn;
    wr_ent.pay.size      = wr_size;
    wr_ent.pay.dirty     = wr_dirty;
    wr_ent.pay.cacheable = wr_cacheable;
    wr_ent.pay.prot      = wr_prot;
  end

  utlb_store #(.N_ENTRIES(N_ENTRIES)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_ent (wr_ent),
    .ents   (ents)
  );

  utlb_match #(.N_ENTRIES(N_ENTRIES)) u_match (
    .ents     (ents),
    .va_vpn   (req_va[VA_W-1:PG_LSB]),
    .cur_asid (cur_asid),
    .use_asid (use_asid),
    .hit_vec  (hit_vec),
    .sel_pay  (sel_pay)
  );

  utlb_resolve #(.N_ENTRIES(N_ENTRIES)) u_resolve (
    .hit_vec   (hit_vec),
    .sel_pay   (sel_pay),
    .va        (req_va),
    .is_write  (req_write),
    .is_user   (!req_priv),
    .ok        (res_ok),
    .code      (res_code),
    .pa        (res_pa),
    .cacheable (res_cache)
  );

  utlb_urc #(.N_ENTRIES(N_ENTRIES)) u_urc (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (fire),
    .limit (urb),
    .count (urc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_code      <= '0;
      rsp_pa        <= '0;
      rsp_cacheable <= 1'b0;
    end else if (fire) begin
      rsp_valid     <= 1'b1;
      rsp_hit       <= res_ok;
      rsp_code      <= res_code;
      rsp_pa        <= res_pa;
      rsp_cacheable <= res_cache;
    end else if (rsp_ready) begin
      rsp_valid     <= 1'b0;
    end
  end

endmodule

// File: rtl/utlb_xlate_chk.sv
module utlb_xlate_chk
  import utlb_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [IDX_W-1:0] urb,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [11:0]      rsp_code,
  input logic [31:0]      rsp_pa,
  input logic [IDX_W-1:0] urc
);

  logic fire;
  logic wr_q;
  assign fire = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else if (fire) wr_q <= req_write;
  end

  p_rsp_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) &&
                                   $stable(rsp_pa) && $stable(rsp_hit)));

  p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_urc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((urc == $past(urc) + 1'b1) || (urc == '0)));

  p_urc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(urc));

  p_urc_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (urb != '0) && (urc <= urb)) |=> (urc <= $past(urb)));

  p_write_codes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ((rsp_code == EC_MISS_WR) || (rsp_code == EC_INIT_WR))) |-> wr_q);

  p_read_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ((rsp_code == EC_MISS_RD) || (rsp_code == EC_PROT_RD))) |-> !wr_q);

  p_fault_no_pa_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_pa == '0));

endmodule

bind utlb_xlate utlb_xlate_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/utlb_xlate_bench.sv
module utlb_xlate_bench;

  localparam int CLK_P = 10;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_priv = 1'b0;
  logic [7:0]  cur_asid = '0;
  logic        sv_mode = 1'b0;
  logic [5:0]  urb = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [21:0] wr_vpn = '0;
  logic [21:0] wr_ppn = '0;
  logic [7:0]  wr_asid = '0;
  logic [1:0]  wr_size = '0;
  logic        wr_valid = 1'b0;
  logic        wr_shared = 1'b0;
  logic        wr_dirty = 1'b0;
  logic        wr_cacheable = 1'b0;
  logic [1:0]  wr_prot = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [11:0] rsp_code;
  logic [31:0] rsp_pa;
  logic        rsp_cacheable;
  logic [5:0]  urc;

  always #(CLK_P/2) clk = ~clk;

  utlb_xlate u_utlb_xlate (.*);

  // Reference table
  logic [21:0] m_vpn  [N];
  logic [21:0] m_ppn  [N];
  logic [7:0]  m_asid [N];
  logic [1:0]  m_size [N];
  logic        m_v [N], m_sh [N], m_d [N], m_c [N];
  logic [1:0]  m_pr [N];
  logic [5:0]  m_urc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] cmp_mask(input logic [1:0] sz);
    case (sz)
      2'd0: return 22'h3FFFFF;
      2'd1: return 22'h3FFFFC;
      2'd2: return 22'h3FFFC0;
      default: return 22'h3FFC00;
    endcase
  endfunction

  function automatic logic [11:0] exp_code(input logic [31:0] va, input bit wr, input bit priv,
                                           input logic [7:0] asid, input bit sv, output logic [31:0] pa,
                                           output bit cach);
    int cnt = 0;
    int hi = 0;
    bit use_id = !sv || !priv;
    logic [31:0] om;
    pa = '0;
    cach = 0;
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && (m_sh[i] || !use_id || m_asid[i] == asid) &&
          (((m_vpn[i] ^ va[31:10]) & cmp_mask(m_size[i])) == 0)) begin
        cnt++;
        hi = i;
      end
    end
    if (cnt > 1) return 12'h140;
    if (cnt == 0) return wr ? 12'h060 : 12'h040;
    if (!priv && !m_pr[hi][1]) return wr ? 12'h0C0 : 12'h0A0;
    if (wr && !m_pr[hi][0]) return 12'h0C0;
    if (wr && !m_d[hi]) return 12'h080;
    om = ~{cmp_mask(m_size[hi]), 10'h000};
    pa = ({m_ppn[hi], 10'h000} & ~om) | (va & om);
    cach = m_c[hi];
    return 12'h000;
  endfunction

  function automatic logic [5:0] next_urc(input logic [5:0] u, input logic [5:0] lim);
    int n = int'(u) + 1;
    if ((lim != 0 && n > int'(lim)) || n > 63) return 6'd0;
    return 6'(n);
  endfunction

  // drive a write at negedge; it lands on the next posedge
  task automatic put_ent(input int idx, input logic [21:0] vpn, input logic [21:0] ppn,
                         input logic [7:0] asid, input logic [1:0] sz, input bit v, input bit sh,
                         input bit d, input bit c, input logic [1:0] pr);
    wr_en = 1; wr_idx = 6'(idx); wr_vpn = vpn; wr_ppn = ppn; wr_asid = asid; wr_size = sz;
    wr_valid = v; wr_shared = sh; wr_dirty = d; wr_cacheable = c; wr_prot = pr;
    @(posedge clk);
    m_vpn[idx] = vpn; m_ppn[idx] = ppn; m_asid[idx] = asid; m_size[idx] = sz;
    m_v[idx] = v; m_sh[idx] = sh; m_d[idx] = d; m_c[idx] = c; m_pr[idx] = pr;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) put_ent(i, '0, '0, '0, 2'd0, 0, 0, 0, 0, 2'd0);
  endtask

  task automatic look(input logic [31:0] va, input bit wr, input bit priv, input logic [7:0] asid,
                      input bit sv, input string req);
    logic [11:0] ec;
    logic [31:0] epa;
    bit ecach;
    ec = exp_code(va, wr, priv, asid, sv, epa, ecach);
    req_valid = 1; req_va = va; req_write = wr; req_priv = priv; cur_asid = asid; sv_mode = sv;
    @(posedge clk);
    m_urc = next_urc(m_urc, urb);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1, {req, " R9 rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk(rsp_code === ec, {req, " code"}, 32'(rsp_code), 32'(ec));
    chk(rsp_hit === (ec == 0), {req, " R7 hit"}, 32'(rsp_hit), 32'(ec == 0));
    chk(rsp_pa === epa, {req, " R7 pa"}, rsp_pa, epa);
    chk(rsp_cacheable === ecach, {req, " R7 cacheable"}, 32'(rsp_cacheable), 32'(ecach));
    chk(urc === m_urc, {req, " R8 urc"}, 32'(urc), 32'(m_urc));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] va;
    logic [21:0] pool [8];
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = '0; m_ppn[i] = '0; m_asid[i] = '0; m_size[i] = '0;
      m_v[i] = 0; m_sh[i] = 0; m_d[i] = 0; m_c[i] = 0; m_pr[i] = '0;
    end
    m_urc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    chk(rsp_valid === 1'b0, "R9 reset rsp_valid", 32'(rsp_valid), 0);
    chk(urc === 6'd0, "R8 reset urc", 32'(urc), 0);
    chk(req_ready === 1'b1, "R9 reset req_ready", 32'(req_ready), 1);

    // R1 / R5: empty table
    look(32'h4812_3456, 0, 1, 8'h01, 0, "R1 R5 empty read");
    look(32'h4812_3456, 1, 1, 8'h01, 0, "R1 R5 empty write");
    put_ent(3, 22'h12048D, 22'h0A5A5A, 8'h01, 2'd3, 0, 0, 1, 1, 2'b11);
    look(32'h4812_3456, 0, 1, 8'h01, 0, "R1 invalid entry");

    // R3: 1 MB page (vpn bits 9:0 ignored)
    put_ent(3, 22'h12048D, 22'h0A5A5A, 8'h01, 2'd3, 1, 0, 1, 1, 2'b11);
    look(32'h4812_3456 ^ 32'h000F_FC00, 0, 1, 8'h01, 0, "R3 1M inside");
    look(32'h4812_3456 ^ 32'h0010_0000, 0, 1, 8'h01, 0, "R3 1M outside");
    put_ent(3, 22'h12048D, 22'h0A5A5A, 8'h01, 2'd1, 1, 0, 1, 0, 2'b11);
    look(32'h4812_3456 ^ 32'h0000_0C00, 1, 1, 8'h01, 0, "R3 4K inside");
    look(32'h4812_3456 ^ 32'h0000_1000, 1, 1, 8'h01, 0, "R3 4K outside");
    put_ent(3, 22'h12048D, 22'h0A5A5A, 8'h01, 2'd2, 1, 0, 1, 1, 2'b11);
    look(32'h4812_3456 ^ 32'h0000_FC00, 0, 1, 8'h01, 0, "R3 64K inside");
    put_ent(3, 22'h12048D, 22'h0A5A5A, 8'h01, 2'd0, 1, 0, 1, 1, 2'b11);
    look(32'h4812_3456 ^ 32'h0000_0400, 0, 1, 8'h01, 0, "R3 1K outside");
    look(32'h4812_3456, 0, 1, 8'h01, 0, "R3 1K exact");

    // R4: duplicate
    put_ent(40, 22'h12048D, 22'h000111, 8'h01, 2'd0, 1, 1, 1, 1, 2'b11);
    look(32'h4812_3456, 0, 1, 8'h01, 0, "R4 multiple");
    put_ent(40, '0, '0, '0, 2'd0, 0, 0, 0, 0, 2'd0);

    // R2: identifier filtering
    put_ent(3, 22'h12048D, 22'h0A5A5A, 8'h05, 2'd0, 1, 0, 1, 1, 2'b11);
    look(32'h4812_3456, 0, 1, 8'h06, 0, "R2 mismatch sv0");
    look(32'h4812_3456, 0, 1, 8'h06, 1, "R2 priv sv1 ignore");
    look(32'h4812_3456, 0, 0, 8'h06, 1, "R2 user sv1 checked");
    put_ent(3, 22'h12048D, 22'h0A5A5A, 8'h05, 2'd0, 1, 1, 1, 1, 2'b11);
    look(32'h4812_3456, 0, 0, 8'h06, 0, "R2 shared");

    // R6: check order
    put_ent(3, 22'h12048D, 22'h0A5A5A, 8'h05, 2'd0, 1, 1, 0, 1, 2'b00);
    look(32'h4812_3456, 1, 0, 8'h05, 0, "R6 user write prot00");
    look(32'h4812_3456, 0, 0, 8'h05, 0, "R6 user read prot00");
    put_ent(3, 22'h12048D, 22'h0A5A5A, 8'h05, 2'd0, 1, 1, 0, 1, 2'b10);
    look(32'h4812_3456, 1, 1, 8'h05, 0, "R6 priv write ro");
    look(32'h4812_3456, 0, 0, 8'h05, 0, "R6 user read ro ok");
    put_ent(3, 22'h12048D, 22'h0A5A5A, 8'h05, 2'd0, 1, 1, 0, 1, 2'b01);
    look(32'h4812_3456, 1, 1, 8'h05, 0, "R6 priv write clean");
    look(32'h4812_3456, 1, 0, 8'h05, 0, "R6 user write before dirty");

    // R10: write and lookup on the same edge
    put_ent(3, 22'h12048D, 22'h0A5A5A, 8'h05, 2'd0, 1, 1, 1, 1, 2'b11);
    wr_en = 1; wr_idx = 6'd3; wr_valid = 0;
    req_valid = 1; req_va = 32'h4812_3456; req_write = 0; req_priv = 1; cur_asid = 8'h05; sv_mode = 0;
    @(posedge clk);
    m_urc = next_urc(m_urc, urb);
    m_v[3] = 0;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    chk(rsp_code === 12'h000, "R10 same edge sees old", 32'(rsp_code), 0);
    look(32'h4812_3456, 0, 1, 8'h05, 0, "R10 overwrite invalid");

    // R9: back-pressure
    put_ent(7, 22'h001000, 22'h002000, 8'h00, 2'd1, 1, 1, 1, 1, 2'b11);
    rsp_ready = 0;
    req_valid = 1; req_va = 32'h0040_0123; req_write = 0; req_priv = 1;
    @(posedge clk);
    m_urc = next_urc(m_urc, urb);
    @(negedge clk);
    chk(rsp_code === 12'h000, "R9 first result", 32'(rsp_code), 0);
    req_va = 32'h7700_0000;
    @(posedge clk);
    @(negedge clk);
    chk(req_ready === 1'b0, "R9 stall ready low", 32'(req_ready), 0);
    chk(rsp_code === 12'h000 && rsp_pa === 32'h0080_0123, "R9 held result", rsp_pa, 32'h0080_0123);
    chk(urc === m_urc, "R8 urc frozen in stall", 32'(urc), 32'(m_urc));
    rsp_ready = 1;
    @(posedge clk);
    m_urc = next_urc(m_urc, urb);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1 && rsp_code === 12'h040, "R9 second result", 32'(rsp_code), 32'h040);
    chk(urc === m_urc, "R8 urc after release", 32'(urc), 32'(m_urc));

    // R8: bounded counter
    urb = 6'd2;
    for (int k = 0; k < 6; k++) look(32'h0040_0000, 0, 1, 8'h00, 0, "R8 urb=2");
    urb = 6'd0;

    // random traffic
    clear_all();
    for (int j = 0; j < 8; j++) pool[j] = 22'($urandom);
    for (int j = 0; j < 40; j++)
      put_ent($urandom_range(0, 63), pool[$urandom_range(0, 7)] ^ 22'($urandom & 32'h3FF),
              22'($urandom), 8'($urandom_range(1, 2)), 2'($urandom), 1, ($urandom_range(0, 3) == 0),
              1'($urandom), 1'($urandom), 2'($urandom));
    for (int j = 0; j < 500; j++) begin
      if (j == 300) urb = 6'd17;
      if (j == 400) urb = 6'd5;
      va = {pool[$urandom_range(0, 7)] ^ 22'($urandom & 32'h3FF), 10'($urandom)};
      look(va, 1'($urandom), 1'($urandom), 8'($urandom_range(1, 2)), 1'($urandom),
           "R2 R3 R4 R5 R6 R7 R8 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule